// File: doc/BRIEF.md
# Serial Mixer Control Port

This block takes a slow synchronous serial stream and uses it to program the gain and routing of an eight-input stereo mixer. A host lowers the write-enable line, clocks out one 8-bit word with the most significant bit first, and raises write-enable again. Words arrive in pairs. The first word of a pair names a mixer input and says whether that input feeds the left bus, the right bus, both or neither. The second word gives that input's 6-bit attenuation code.

A mode input selects one of two commit schemes. In three-wire mode, each completed word reaches the live outputs as soon as write-enable rises. In four-wire mode, completed words update only a staging copy of the settings. The whole staging copy is moved into the live registers on a rising edge of a separate load line. Several ports can share one load line, so they all change at the same moment. A one-cycle update pulse marks every change of the live registers. All serial inputs are asynchronous to the system clock and pass through synchronizers before use.

Top module: `mixer_ctl_port`

## Requirements
- R1: After reset, every channel's attenuation is 63 (all ones), every left and right enable is 0, the update pulse is low, and the next word is taken as an address word.
- R2: A word is 8 bits, sent most significant bit first. Each bit is sampled on a rising edge of the serial clock, and bits are shifted only while write-enable is low.
- R3: Complete words alternate between address and attenuation, starting with address.
- R4: In an address word, bits 2:0 select the channel, bit 3 is the left enable and bit 4 is the right enable. Bits 7:5 are ignored.
- R5: An attenuation word writes its bits 5:0 to the channel chosen by the most recent address word. Bits 7:6 are ignored.
- R6: With mode_4w_i = 0, the routing bits reach the live outputs when the address word completes. The attenuation reaches the live outputs when the attenuation word completes.
- R7: With mode_4w_i = 1, completed words change only the staging copy. The live outputs stay unchanged until a rising edge of ld_i, which copies all staged settings at once.
- R8: A word with fewer or more than 8 serial clock edges while write-enable is low is discarded. It does not advance the address/attenuation alternation.
- R9: upd_o is a single-cycle pulse for each live update: one per completed word in three-wire mode and one per rising edge of ld_i in four-wire mode. ld_i has no effect in three-wire mode.
- R10: Writing one channel leaves the settings of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial bit clock, asynchronous |
| sdi_i | input | 1 | Serial data, MSB first |
| wr_n_i | input | 1 | Write enable, active low; frames a word |
| ld_i | input | 1 | Load strobe; a rising edge commits the staged settings in four-wire mode |
| mode_4w_i | input | 1 | 0 = three-wire (commit per word), 1 = four-wire (commit on load) |
| atten_o | output | 48 | Attenuation of channel c in bits [6c+5:6c] |
| left_en_o | output | 8 | Left-bus enable, one bit per channel |
| right_en_o | output | 8 | Right-bus enable, one bit per channel |
| upd_o | output | 1 | One-cycle pulse when the live registers change |

## Verification
The bench sends words of 5 and 9 bits and then sends a normal pair. A design that counted those bad words, or flipped the address/attenuation phase on them, would program the wrong channel or store an address as an attenuation. In four-wire mode it checks the outputs after the words but before the load edge. It also pulses ld_i in three-wire mode. An early commit, or a spurious update, shows up as a changed output or an unexpected upd_o count. Words with the ignored high bits set, and attenuation patterns that differ only in bit order, expose a design that decodes the wrong bits or shifts LSB first.

// File: rtl/mixctl_pkg.sv
package mixctl_pkg;
   typedef enum logic {
      PH_ADDR  = 1'b0,
      PH_ATTEN = 1'b1
   } phase_e;
endpackage

// File: rtl/mixctl_sync.sv
module mixctl_sync #(
   parameter int         W      = 4,
   parameter int         STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

   initial begin
      stages_ok_chk : assert (STAGES >= 2)
         else $error("mixctl_sync: STAGES must be at least 2");
   end
endmodule

// File: rtl/mixctl_shift.sv
module mixctl_shift #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic              wr_s,
   output logic              frame_ok,
   output logic [WORD_W-1:0] frame_byte
);
   localparam int CNT_W = $clog2(WORD_W + 2);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] OVER = CNT_W'(WORD_W + 1);

   logic              sclk_q, wr_q;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] sh;
   logic              sclk_rise, wr_fall, wr_rise;

   assign sclk_rise = sclk_s & ~sclk_q;
   assign wr_fall   = ~wr_s & wr_q;
   assign wr_rise   = wr_s & ~wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         wr_q   <= 1'b1;
         cnt    <= '0;
         sh     <= '0;
      end else begin
         sclk_q <= sclk_s;
         wr_q   <= wr_s;
         if (wr_fall) begin
            cnt <= '0;
         end else if (!wr_s && sclk_rise) begin
            sh <= {sh[WORD_W-2:0], sdi_s};
            if (cnt != OVER) cnt <= cnt + 1'b1;
         end
      end
   end

   assign frame_ok   = wr_rise && (cnt == FULL);
   assign frame_byte = sh;

   // R2
   shift_idle_chk : assert property (@(posedge clk) disable iff (!rst_n)
      wr_s |=> $stable(sh));
endmodule

// File: rtl/mixctl_regs.sv
module mixctl_regs
   import mixctl_pkg::*;
#(
   parameter int N_CH    = 8,
   parameter int ATTEN_W = 6,
   parameter int WORD_W  = 8,
   parameter int L_BIT   = 3,
   parameter int R_BIT   = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      frame_ok,
   input  logic [WORD_W-1:0]         frame_byte,
   input  logic                      mode_4w,
   input  logic                      ld_s,
   output logic [N_CH*ATTEN_W-1:0]   atten_o,
   output logic [N_CH-1:0]           left_o,
   output logic [N_CH-1:0]           right_o,
   output logic                      upd_o
);
   localparam int SEL_W = $clog2(N_CH);

   phase_e                        phase;
   logic [SEL_W-1:0]              sel;
   logic                          ld_q, ld_rise;
   logic                          wr_addr, wr_att;
   logic [N_CH-1:0][ATTEN_W-1:0]  live_att;
   logic                          unused_hi;

   assign ld_rise   = ld_s & ~ld_q;
   assign wr_addr   = frame_ok && (phase == PH_ADDR);
   assign wr_att    = frame_ok && (phase == PH_ATTEN);
   assign unused_hi = ^frame_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_ADDR;
         sel   <= '0;
         ld_q  <= 1'b0;
         upd_o <= 1'b0;
      end else begin
         ld_q  <= ld_s;
         upd_o <= mode_4w ? ld_rise : frame_ok;
         if (frame_ok) phase <= (phase == PH_ADDR) ? PH_ATTEN : PH_ADDR;
         if (wr_addr)  sel   <= frame_byte[SEL_W-1:0];
      end
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      logic               hit_a, hit_t;
      logic [ATTEN_W-1:0] s_att, l_att;
      logic               s_l, s_r, l_l, l_r;

      assign hit_a = wr_addr && (frame_byte[SEL_W-1:0] == SEL_W'(c));
      assign hit_t = wr_att  && (sel == SEL_W'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_att <= '1;
            s_l   <= 1'b0;
            s_r   <= 1'b0;
         end else begin
            if (hit_a) begin
               s_l <= frame_byte[L_BIT];
               s_r <= frame_byte[R_BIT];
            end
            if (hit_t) s_att <= frame_byte[ATTEN_W-1:0];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            l_att <= '1;
            l_l   <= 1'b0;
            l_r   <= 1'b0;
         end else if (mode_4w) begin
            if (ld_rise) begin
               l_att <= s_att;
               l_l   <= s_l;
               l_r   <= s_r;
            end
         end else begin
            if (hit_a) begin
               l_l <= frame_byte[L_BIT];
               l_r <= frame_byte[R_BIT];
            end
            if (hit_t) l_att <= frame_byte[ATTEN_W-1:0];
         end
      end

      assign live_att[c] = l_att;
      assign left_o[c]   = l_l;
      assign right_o[c]  = l_r;
   end

   assign atten_o = live_att;

   // R9
   upd_one_cycle_chk : assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |=> !upd_o);
   // R9
   live_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o |-> ($stable(live_att) && $stable(left_o) && $stable(right_o)));
   // R7
   four_wire_defer_chk : assert property (@(posedge clk) disable iff (!rst_n)
      (mode_4w && !ld_rise) |=> ($stable(live_att) && $stable(left_o) && $stable(right_o)));
   // R8
   phase_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_ok |=> $stable(phase));
   // R3
   phase_flip_chk : assert property (@(posedge clk) disable iff (!rst_n)
      frame_ok |=> (phase != $past(phase)));
endmodule

// File: rtl/mixer_ctl_port.sv
module mixer_ctl_port #(
   parameter int N_CH     = 8,
   parameter int ATTEN_W  = 6,
   parameter int WORD_W   = 8,
   parameter int L_BIT    = 3,
   parameter int R_BIT    = 4,
   parameter int SYNC_STG = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sclk_i,
   input  logic                    sdi_i,
   input  logic                    wr_n_i,
   input  logic                    ld_i,
   input  logic                    mode_4w_i,
   output logic [N_CH*ATTEN_W-1:0] atten_o,
   output logic [N_CH-1:0]         left_en_o,
   output logic [N_CH-1:0]         right_en_o,
   output logic                    upd_o
);
   localparam int SEL_W = $clog2(N_CH);

   logic [4:0]        sync_q;
   logic              frame_ok;
   logic [WORD_W-1:0] frame_byte;

   // bit order: mode, ld, wr_n, sdi, sclk
   mixctl_sync #(.W(5), .STAGES(SYNC_STG), .RST_VAL(5'b00100)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({mode_4w_i, ld_i, wr_n_i, sdi_i, sclk_i}),
      .q     (sync_q)
   );

   mixctl_shift #(.WORD_W(WORD_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sclk_s     (sync_q[0]),
      .sdi_s      (sync_q[1]),
      .wr_s       (sync_q[2]),
      .frame_ok   (frame_ok),
      .frame_byte (frame_byte)
   );

   mixctl_regs #(
      .N_CH(N_CH), .ATTEN_W(ATTEN_W), .WORD_W(WORD_W), .L_BIT(L_BIT), .R_BIT(R_BIT)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_ok   (frame_ok),
      .frame_byte (frame_byte),
      .mode_4w    (sync_q[4]),
      .ld_s       (sync_q[3]),
      .atten_o    (atten_o),
      .left_o     (left_en_o),
      .right_o    (right_en_o),
      .upd_o      (upd_o)
   );

   initial begin
      cfg_chk : assert (N_CH >= 2 && WORD_W >= 2 && ATTEN_W <= WORD_W
                        && SEL_W <= L_BIT && SEL_W <= R_BIT && L_BIT != R_BIT
                        && L_BIT < WORD_W && R_BIT < WORD_W)
         else $error("mixer_ctl_port: inconsistent field layout parameters");
   end
endmodule

// File: tb/tb_mixer_ctl_port.sv
`timescale 1ns/1ps
module tb_mixer_ctl_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, sdi = 1'b0, wr_n = 1'b1, ld = 1'b0, mode = 1'b0;
   logic [47:0] atten;
   logic [7:0]  left_en, right_en;
   logic        upd;
   int          n_chk = 0, n_fail = 0, upd_cnt = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   mixer_ctl_port dut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .wr_n_i(wr_n),
      .ld_i(ld), .mode_4w_i(mode), .atten_o(atten), .left_en_o(left_en),
      .right_en_o(right_en), .upd_o(upd)
   );

   always @(posedge clk) if (upd) upd_cnt++;

   // vector table: mode, address word, attenuation word, load, channel, expected att/left/right
   localparam int NV = 6;
   localparam logic       V_MODE [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
   localparam logic [7:0] V_ADDR [NV] = '{8'h08, 8'h1F, 8'hE3, 8'h12, 8'h0D, 8'h10};
   localparam logic [7:0] V_ATT  [NV] = '{8'h05, 8'hEA, 8'h00, 8'h11, 8'h3F, 8'h20};
   localparam logic       V_LD   [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
   localparam int         V_CH   [NV] = '{0, 7, 3, 2, 5, 0};
   localparam logic [5:0] V_EATT [NV] = '{6'h05, 6'h2A, 6'h00, 6'h11, 6'h3F, 6'h20};
   localparam logic       V_EL   [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
   localparam logic       V_ER   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int chan(input int ch);
      return {atten[ch*6 +: 6], left_en[ch], right_en[ch]};
   endfunction

   task automatic chk_ch(input int ch, input logic [5:0] a, input logic l, input logic r,
                         input string req);
      int exp;
      exp = {a, l, r};
      chk(chan(ch) == exp, req, chan(ch), exp);
   endtask

   task automatic send(input logic [7:0] b, input int nbits);
      wr_n = 1'b0;
      tick(4);
      for (int i = nbits - 1; i >= 0; i--) begin
         sdi = (i < 8) ? b[i] : 1'b1;
         tick(4);
         sclk = 1'b1;
         tick(4);
         sclk = 1'b0;
      end
      tick(4);
      wr_n = 1'b1;
      tick(10);
   endtask

   task automatic pulse_ld();
      ld = 1'b1;
      tick(6);
      ld = 1'b0;
      tick(8);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      int base;
      tick(5);
      rst_n = 1'b1;
      tick(4);
      // R1: reset state of all channels
      for (int c = 0; c < 8; c++) chk_ch(c, 6'h3F, 1'b0, 1'b0, "R1 reset");
      chk(upd_cnt == 0, "R1 no update", upd_cnt, 0);

      // R2 R4 R5 R6 R7: table walk
      for (int v = 0; v < NV; v++) begin
         mode = V_MODE[v];
         tick(4);
         base = upd_cnt;
         send(V_ADDR[v], 8);
         send(V_ATT[v], 8);
         if (V_LD[v]) pulse_ld();
         chk_ch(V_CH[v], V_EATT[v], V_EL[v], V_ER[v], "R2 R4 R5 R6 R7 vector");
         chk(upd_cnt - base == (V_LD[v] ? 1 : 2), "R9 update count",
             upd_cnt - base, V_LD[v] ? 1 : 2);
      end
      // R10: earlier channels untouched by later writes
      chk_ch(7, 6'h2A, 1'b1, 1'b1, "R10 ch7 kept");
      chk_ch(3, 6'h00, 1'b0, 1'b0, "R10 ch3 kept");
      chk_ch(1, 6'h3F, 1'b0, 1'b0, "R10 ch1 untouched");

      // R7: staged but not loaded
      mode = 1'b1;
      tick(4);
      base = upd_cnt;
      send(8'h0E, 8);
      send(8'h07, 8);
      chk_ch(6, 6'h3F, 1'b0, 1'b0, "R7 before load");
      chk(upd_cnt == base, "R7 no update before load", upd_cnt - base, 0);
      pulse_ld();
      chk_ch(6, 6'h07, 1'b1, 1'b0, "R7 after load");
      chk(upd_cnt - base == 1, "R9 load pulse", upd_cnt - base, 1);

      // R9: load ignored in three-wire mode
      mode = 1'b0;
      tick(4);
      base = upd_cnt;
      pulse_ld();
      chk(upd_cnt == base, "R9 ld ignored", upd_cnt - base, 0);
      chk_ch(6, 6'h07, 1'b1, 1'b0, "R9 ld ignored values");

      // R8: short frame discarded, phase kept
      base = upd_cnt;
      send(8'h1A, 5);
      chk(upd_cnt == base, "R8 short frame", upd_cnt - base, 0);
      send(8'h09, 8);
      send(8'h15, 8);
      chk_ch(1, 6'h15, 1'b1, 1'b0, "R8 R3 pair after short frame");
      // R8: long frame discarded
      base = upd_cnt;
      send(8'h14, 9);
      chk(upd_cnt == base, "R8 long frame", upd_cnt - base, 0);
      send(8'h14, 8);
      send(8'h01, 8);
      chk_ch(4, 6'h01, 1'b0, 1'b1, "R8 R2 pair after long frame");
      chk_ch(1, 6'h15, 1'b1, 1'b0, "R10 ch1 kept");

      finish_run();
   end
endmodule